// File: doc/BRIEF.md
# Push-Pull Pulse-Width Modulator with Termination Latch

This block is a clocked pulse-width modulator for push-pull power stages. A programmable counter sets the switching period. Each period opens with a blanking interval during which both drive outputs are off. A single on-window follows, and its length comes from a duty word. Successive periods steer their pulse to output A and then to output B in turn. Each output therefore fires at most once every two periods, and its duty stays below one half.

A terminate input acts like a pulse-by-pulse current limit. It sets an internal latch at once, and the latch holds both outputs off until the next period starts. Only the start of a period clears the latch, so a period never carries a second pulse. A sync input restarts the period from any count, which lets several units run in lockstep or follow an external clock. The period, blanking and duty words are taken in only at a period boundary, so a change made partway through a period cannot produce a runt pulse. A parameter chooses whether the off state is driven low or high.

Top module: `pp_pwm`

## Requirements
- R1: Without sync, a period lasts P+1 clock cycles, where P is the loaded period word. The count runs 0..P and then returns to 0. Outputs are registered, so the level in a given cycle reflects the count held in the cycle before.
- R2: The first period after reset drives output A. Every period boundary, whether from the count or from sync, switches the pulse to the other output. The two outputs are never active together.
- R3: Both outputs are off while the count is at or below the loaded blanking word D. This gives D+1 blanking cycles at the start of every period.
- R4: After blanking, the selected output is active for min(W, P−D) cycles, where W is the loaded duty word. W=0 gives no pulse. D≥P gives no pulse. A larger W is clamped by the end of the period.
- R5: While term_in is high, both outputs are off in the next cycle. Once term_in has been high, they stay off for the rest of that period even after term_in falls. If term_in is high in the last cycle of a period, the following period is blocked as well.
- R6: The termination latch is cleared only at a period boundary. The next period then pulses normally.
- R7: When sync_in is high, the next cycle starts a new period at count 0. That boundary reloads the settings and switches the output, exactly as a count boundary does.
- R8: period_in, dead_in and duty_in are sampled only at a period boundary, and while reset is active. Changes made inside a period have no effect on that period.
- R9: With OFF_HIGH=0, an output is high when active and low when off. With OFF_HIGH=1, the levels are inverted.
- R10: Reset is synchronous and active high. It drives both outputs to the off level, sets the count to 0, selects output A and loads the settings from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Restart the period on the next cycle |
| term_in | input | 1 | Terminate the current pulse and hold the outputs off for the rest of the period |
| period_in | input | CNT_W | Period word P (period length P+1 cycles) |
| dead_in | input | CNT_W | Blanking word D (D+1 off cycles at the start of each period) |
| duty_in | input | CNT_W | Duty word W (on-cycles per period before clamping) |
| out_a | output | 1 | Drive output A |
| out_b | output | 1 | Drive output B |

## Verification
The bench builds the block twice with CNT_W=8: once with OFF_HIGH=0 and once with OFF_HIGH=1. Both copies receive the same stimulus, so every comparison checks both output polarities against a single expected activity pattern. The 8-bit words allow short periods of a few cycles. That brings the clamp where W exceeds P−D, the case D≥P, a zero period and back-to-back sync pulses into a few hundred cycles. A period of ten cycles still leaves room for mid-period setting changes and terminate pulses at several offsets.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/pp_pwm_timebase.sv
module pp_pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] dead_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] dead_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, per_q, dead_q, duty_q;

  assign wrap_o = sync_in || (cnt_q == per_q);

  always_ff @(posedge clk) begin
    if (rst || wrap_o) begin
      cnt_q  <= '0;
      per_q  <= period_in;
      dead_q <= dead_in;
      duty_q <= duty_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign dead_o = dead_q;
  assign duty_o = duty_q;

  // R7
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> (cnt_q == '0));

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= per_q);
endmodule

// File: rtl/pp_pwm_latch.sv
module pp_pwm_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             wrap_i,
  input  logic             term_in,
  output logic             fire_o
);
  logic past_blank, in_window, ended, held_q;

  assign past_blank = cnt_i > dead_i;
  assign in_window  = past_blank && ((cnt_i - dead_i - 1'b1) < duty_i);
  assign ended      = past_blank && !in_window;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= 1'b0;
    else if (term_in) held_q <= 1'b1;
    else if (wrap_i)  held_q <= 1'b0;
    else if (ended)   held_q <= 1'b1;
  end

  assign fire_o = in_window && !held_q && !term_in;

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (held_q && !wrap_i) |=> held_q);

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |-> !fire_o);
endmodule

// File: rtl/pp_pwm_steer.sv
module pp_pwm_steer
  import pp_pwm_pkg::*;
#(
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic fire_i,
  output logic out_a,
  output logic out_b
);
  localparam logic OFF_LVL = OFF_HIGH;

  side_e side_q;
  logic  act_a, act_b, drv_a, drv_b, out_a_q, out_b_q;

  always_ff @(posedge clk) begin
    if (rst)         side_q <= SIDE_A;
    else if (wrap_i) side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
  end

  assign act_a = fire_i && (side_q == SIDE_A);
  assign act_b = fire_i && (side_q == SIDE_B);

  generate
    if (OFF_HIGH) begin : g_or_style
      assign drv_a = ~act_a;
      assign drv_b = ~act_b;
    end else begin : g_nor_style
      assign drv_a = act_a;
      assign drv_b = act_b;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a_q <= OFF_LVL;
      out_b_q <= OFF_LVL;
    end else begin
      out_a_q <= drv_a;
      out_b_q <= drv_b;
    end
  end

  assign out_a = out_a_q;
  assign out_b = out_b_q;

  // R2
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !((out_a_q != OFF_LVL) && (out_b_q != OFF_LVL)));

  // R2
  side_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_i |=> (side_q != $past(side_q)));
endmodule

// File: rtl/pp_pwm.sv
module pp_pwm #(
  parameter int CNT_W    = 8,
  parameter bit OFF_HIGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             term_in,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] dead_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             out_a,
  output logic             out_b
);
  localparam logic OFF_LVL = OFF_HIGH;

  logic [CNT_W-1:0] cnt, dead, duty;
  logic             wrap, fire;

  pp_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .sync_in(sync_in),
    .period_in(period_in), .dead_in(dead_in), .duty_in(duty_in),
    .cnt_o(cnt), .dead_o(dead), .duty_o(duty), .wrap_o(wrap)
  );

  pp_pwm_latch #(.CNT_W(CNT_W)) u_latch (
    .clk(clk), .rst(rst), .cnt_i(cnt), .dead_i(dead), .duty_i(duty),
    .wrap_i(wrap), .term_in(term_in), .fire_o(fire)
  );

  pp_pwm_steer #(.OFF_HIGH(OFF_HIGH)) u_steer (
    .clk(clk), .rst(rst), .wrap_i(wrap), .fire_i(fire),
    .out_a(out_a), .out_b(out_b)
  );

  // R5
  term_off_chk: assert property (@(posedge clk) disable iff (rst)
    term_in |=> ((out_a == OFF_LVL) && (out_b == OFF_LVL)));
endmodule

// File: tb/pp_pwm_test.sv
module pp_pwm_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0, term_in = 1'b0;
  logic [7:0] period_in = 8'd9, dead_in = 8'd1, duty_in = 8'd3;
  logic a0, b0, a1, b1;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_pwm #(.CNT_W(8), .OFF_HIGH(1'b0)) uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .term_in(term_in),
    .period_in(period_in), .dead_in(dead_in), .duty_in(duty_in),
    .out_a(a0), .out_b(b0));

  pp_pwm #(.CNT_W(8), .OFF_HIGH(1'b1)) uut_inv (
    .clk(clk), .rst(rst), .sync_in(sync_in), .term_in(term_in),
    .period_in(period_in), .dead_in(dead_in), .duty_in(duty_in),
    .out_a(a1), .out_b(b1));

  // expected activity {A,B}, built from the requirements
  logic [1:0] exp_q[$];
  string      req_q[$];
  int m_pos, m_per, m_dead, m_duty;
  bit m_side, m_blk;

  always @(posedge clk) begin
    bit on, over;
    logic [1:0] e;
    if (rst) begin
      m_pos = 0; m_per = period_in; m_dead = dead_in; m_duty = duty_in;
      m_side = 0; m_blk = 0; e = 2'b00;
    end else begin
      on   = !m_blk && !term_in && (m_pos > m_dead) && (m_pos <= m_dead + m_duty);
      over = (m_pos > m_dead) && (m_pos > m_dead + m_duty);
      e = {on && !m_side, on && m_side};
      if (sync_in || m_pos == m_per) begin
        m_pos = 0; m_per = period_in; m_dead = dead_in; m_duty = duty_in;
        m_side = !m_side; m_blk = term_in;
      end else begin
        m_pos = m_pos + 1;
        m_blk = m_blk || term_in || over;
      end
    end
    exp_q.push_back(e);
    req_q.push_back(cur_req);
  end

  // monitor: compares both polarity variants away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_cmp++;
      if ({a0, b0} !== e || {a1, b1} !== ~e) begin
        n_bad++;
        $display("FAIL %s R9 at %0t: actual nor=%b%b or=%b%b expected nor=%b or=%b",
                 r, $time, a0, b0, a1, b1, e, ~e);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int p, input int d, input int w);
    @(negedge clk);
    period_in = p[7:0]; dead_in = d[7:0]; duty_in = w[7:0];
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    cur_req = "R10";
    run(3);
    rst = 1'b0;
    cur_req = "R1";  run(25);
    cur_req = "R2";  run(20);
    cur_req = "R3";  cfg(9, 4, 3); run(30);
    cur_req = "R4";  cfg(9, 1, 0); run(25);
    cfg(9, 2, 200); run(25);
    cfg(9, 12, 5); run(25);
    cfg(0, 0, 4);  run(8);
    cfg(3, 0, 9);  run(16);
    cur_req = "R8";  cfg(9, 1, 3); run(14);
    cfg(5, 0, 1); run(3); cfg(7, 2, 2); run(30);
    cur_req = "R5";  cfg(9, 1, 6); run(13);
    term_in = 1'b1; @(negedge clk); term_in = 1'b0; run(4);
    term_in = 1'b1; run(14); term_in = 1'b0;
    cur_req = "R6";  run(30);
    cur_req = "R7";  pulse_sync(); run(3); pulse_sync(); run(7);
    @(negedge clk); sync_in = 1'b1; run(3); sync_in = 1'b0; run(25);
    cur_req = "R9";  cfg(9, 1, 4); run(30);
    cur_req = "R10"; rst = 1'b1; run(2); rst = 1'b0; run(15);
    run(2);
    done = 1'b1;
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
    end
  end
endmodule